// File: doc/BRIEF.md
# Quad-channel DAC serial control logic

This block is the digital front end of a four-channel digital-to-analog converter. A host writes command words over a three-wire serial link: an active-low chip select, a serial clock and a data line. All four serial pins and the load strobe are brought into a faster system clock through two-flop synchronizers. Edges are detected in that clock domain. Bits enter a shift register on each rising serial-clock edge while chip select is low. When chip select is released, the newest word is decoded. It either loads a code into one channel's staging register or shuts channels down.

Each channel keeps a staging register and a live register. An active-low, level-sensitive load strobe makes all four live registers follow their staging registers for as long as it is held low. An asynchronous active-low clear zeroes every staging and live register. A shut-down channel drives a zero code. The parameter `CODE_W` chooses 12-bit codes with 16-bit words, or 10-bit codes with 14-bit words.

The interface carries no stream of data. Every pin is a plain level, and there is no valid/ready handshake and no back-pressure. The host paces the serial clock slowly enough for the synchronizers to see each of its levels.

Top module: `quad_dac_ctrl`

## Requirements
- R1: A command word is `CODE_W`+4 bits long and is sent MSB first. Counted from the MSB down, it holds the all-off bit, the single-off bit, a 2-bit channel address and then the code, with the code's MSB sent first.
- R2: The shift register moves only on a rising serial-clock edge while chip select is low. Serial-clock edges taken while chip select is high change nothing, so a later empty frame decodes the word already held.
- R3: On chip-select release, only the last `CODE_W`+4 bits shifted in are decoded. Any earlier bits of the same frame are discarded.
- R4: Address 0 selects channel A, 1 selects B, 2 selects C and 3 selects D. Channel n appears on `code_o[n*CODE_W +: CODE_W]` and on `shdn_o[n]`.
- R5: A word with the all-off bit set raises all four shutdown flags, whatever its other bits hold.
- R6: A word with the all-off bit clear and the single-off bit set raises only the addressed channel's flag. It writes no staging register.
- R7: A word with both off bits clear writes its code into the addressed staging register and clears only that channel's shutdown flag.
- R8: While `ldac_n` is low, every live register follows its staging register, including during a serial frame. While `ldac_n` is high, the live registers hold.
- R9: A low `clr_n` zeroes all staging and live registers at once. It leaves the shift register contents and the shutdown flags unchanged.
- R10: After power-on reset, all codes are zero and no channel is shut down.
- R11: A shut-down channel outputs code zero. Its registers can still be loaded, and the live code appears once the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low, clears everything |
| clr_n | input | 1 | Asynchronous clear of staging and live code registers, active low |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, data taken on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| ldac_n | input | 1 | Level-sensitive load strobe, active low |
| code_o | output | 4*CODE_W | Live codes of channels A..D, channel A in the low slice, zero while shut down |
| shdn_o | output | 4 | Per-channel shutdown flags, bit n for channel n |

## Verification
The hardest state to reach from the pins is a shift register that keeps an old word after the code registers have been cleared and after stray serial clocks have arrived with chip select high. The stimulus first commits a load word. It then pulses `clr_n`, toggles the serial clock and data with chip select high, and finally opens and closes chip select with no clocks in between. The replayed load and the strobe that follows must show the original code again. Discarding the leading bits is exercised with a 24-bit frame whose first byte is junk. Shutdown gating is exercised by putting every channel into shutdown, then waking the channels one at a time with loads.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int NCH    = 4;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    CMD_LOAD     = 2'd0,
    CMD_OFF_ONE  = 2'd1,
    CMD_OFF_ALL  = 2'd2
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic all_off, input logic one_off);
    if (all_off)      return CMD_OFF_ALL;
    else if (one_off) return CMD_OFF_ONE;
    else              return CMD_LOAD;
  endfunction
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rst_val,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= rst_val[i];
        s2 <= rst_val[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);
  logic              sclk_d, cs_d;
  logic [WORD_W-1:0] sh_q;
  logic              shift_en;

  assign shift_en = !cs_s && sclk_s && !sclk_d;
  assign commit_o = cs_s && !cs_d;
  assign word_o   = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
      sh_q   <= '0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
      if (shift_en) sh_q <= {sh_q[WORD_W-2:0], sdi_s};
    end
  end

  AST_HOLD_WHILE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(sh_q)); // R2
  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o); // R3
endmodule

// File: rtl/dacfe_chan.sv
module dacfe_chan #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              clr_n,
  input  logic              ld_en,
  input  logic              off_set,
  input  logic [CODE_W-1:0] code_in,
  input  logic              ldac_s,
  output logic [CODE_W-1:0] code_o,
  output logic              sd_o
);
  logic              reg_rst_n;
  logic [CODE_W-1:0] in_q, out_q;
  logic              sd_q;

  assign reg_rst_n = por_n & clr_n;

  always_ff @(posedge clk or negedge reg_rst_n) begin
    if (!reg_rst_n) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      if (ld_en)   in_q  <= code_in;
      if (!ldac_s) out_q <= in_q;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       sd_q <= 1'b0;
    else if (off_set) sd_q <= 1'b1;
    else if (ld_en)   sd_q <= 1'b0;
  end

  assign code_o = sd_q ? '0 : out_q;
  assign sd_o   = sd_q;

  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (!por_n || !clr_n)
    ldac_s |=> $stable(out_q)); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!por_n)
    !clr_n |-> (in_q == '0 && out_q == '0)); // R9
  AST_OFF_NO_WRITE: assert property (@(posedge clk) disable iff (!por_n || !clr_n)
    off_set |=> $stable(in_q)); // R6
  AST_LOAD_WAKES: assert property (@(posedge clk) disable iff (!por_n)
    (ld_en && !off_set) |=> !sd_q); // R7
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl #(
  parameter int CODE_W = 12
) (
  input  logic                              clk,
  input  logic                              por_n,
  input  logic                              clr_n,
  input  logic                              cs_n,
  input  logic                              sclk,
  input  logic                              sdi,
  input  logic                              ldac_n,
  output logic [dacfe_pkg::NCH*CODE_W-1:0]  code_o,
  output logic [dacfe_pkg::NCH-1:0]         shdn_o
);
  import dacfe_pkg::*;

  localparam int WORD_W = CODE_W + 2 + ADDR_W;

  logic [3:0]        raw, synced;
  logic              cs_s, sclk_s, sdi_s, ldac_s;
  logic [WORD_W-1:0] word;
  logic              commit;
  cmd_e              cmd;
  logic [ADDR_W-1:0] addr;
  logic [CODE_W-1:0] code;

  assign raw = {ldac_n, sdi, sclk, cs_n};

  dacfe_sync #(.N(4)) u_sync (
    .clk(clk), .rst_n(por_n), .rst_val(4'b1001), .d(raw), .q(synced)
  );
  assign cs_s   = synced[0];
  assign sclk_s = synced[1];
  assign sdi_s  = synced[2];
  assign ldac_s = synced[3];

  dacfe_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(por_n), .cs_s(cs_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .word_o(word), .commit_o(commit)
  );

  assign cmd  = decode_cmd(word[WORD_W-1], word[WORD_W-2]);
  assign addr = word[CODE_W +: ADDR_W];
  assign code = word[CODE_W-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit, ld_en, off_set;
    assign hit     = (addr == ADDR_W'(c));
    assign ld_en   = commit && (cmd == CMD_LOAD) && hit;
    assign off_set = commit && ((cmd == CMD_OFF_ALL) || ((cmd == CMD_OFF_ONE) && hit));

    dacfe_chan #(.CODE_W(CODE_W)) u_chan (
      .clk(clk), .por_n(por_n), .clr_n(clr_n), .ld_en(ld_en), .off_set(off_set),
      .code_in(code), .ldac_s(ldac_s),
      .code_o(code_o[c*CODE_W +: CODE_W]), .sd_o(shdn_o[c])
    );
  end

  AST_ALL_OFF: assert property (@(posedge clk) disable iff (!por_n)
    (commit && cmd == CMD_OFF_ALL) |=> (&shdn_o)); // R5
  AST_ONE_OFF_ONLY: assert property (@(posedge clk) disable iff (!por_n)
    (commit && cmd == CMD_OFF_ONE) |=> ($countones(shdn_o & ~$past(shdn_o)) <= 1)); // R6
endmodule

// File: tb/quad_dac_ctrl_test.sv
module quad_dac_ctrl_test;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic por_n = 1'b0, clr_n = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, ldac_n = 1'b1;
  logic [4*CW-1:0] code_o;
  logic [3:0]      shdn_o;

  int checks = 0, errors = 0;
  logic [CW-1:0] in_m [4];
  logic [CW-1:0] out_m [4];
  logic          sd_m [4];
  logic [15:0]   last_w;
  logic          strobe_low = 1'b0;

  always #2 clk = ~clk;

  quad_dac_ctrl #(.CODE_W(CW)) uut (
    .clk(clk), .por_n(por_n), .clr_n(clr_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .ldac_n(ldac_n), .code_o(code_o), .shdn_o(shdn_o)
  );

  function automatic logic [15:0] mk(input logic a, input logic s, input logic [1:0] ad, input logic [CW-1:0] c);
    return {a, s, ad, c};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1 R5 R6 R7: reference model of one decoded word
  task automatic apply(input logic [15:0] w);
    if (w[15]) begin
      for (int c = 0; c < 4; c++) sd_m[c] = 1'b1;
    end else if (w[14]) begin
      sd_m[w[13:12]] = 1'b1;
    end else begin
      in_m[w[13:12]] = w[11:0];
      sd_m[w[13:12]] = 1'b0;
    end
    if (strobe_low) for (int c = 0; c < 4; c++) out_m[c] = in_m[c];
    last_w = w;
  endtask

  task automatic send(input logic [31:0] bits, input int n);
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      sclk = 1'b0;
      wait_clk(3);
      sclk = 1'b1;
      wait_clk(3);
    end
    sclk = 1'b0;
    wait_clk(3);
    cs_n = 1'b1;
    wait_clk(10);
    apply(bits[15:0]);
  endtask

  task automatic strobe();
    ldac_n = 1'b0;
    wait_clk(8);
    ldac_n = 1'b1;
    wait_clk(8);
    for (int c = 0; c < 4; c++) out_m[c] = in_m[c];
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < 4; c++) begin
      logic [CW-1:0] got, exp;
      got = code_o[c*CW +: CW];
      exp = sd_m[c] ? '0 : out_m[c];
      checks++;
      if (got !== exp || shdn_o[c] !== sd_m[c]) begin
        errors++;
        $display("FAIL %s ch%0d code %h expected %h, shdn %b expected %b",
                 tag, c, got, exp, shdn_o[c], sd_m[c]);
      end
    end
  endtask

  initial begin : watchdog
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++) begin
      in_m[c] = '0; out_m[c] = '0; sd_m[c] = 1'b0;
    end
    last_w = '0;
    wait_clk(5);
    por_n = 1'b1;
    wait_clk(5);
    check_all("R10 reset state");

    // R1 R4 R8: sweep every address with several codes; hold before strobe, follow after
    for (int ch = 0; ch < 4; ch++) begin
      for (int k = 0; k < 4; k++) begin
        logic [CW-1:0] cd;
        cd = CW'((ch * 1237 + k * 811 + 5) & 12'hFFF);
        send({16'h0, mk(1'b0, 1'b0, 2'(ch), cd)}, 16);
        check_all("R8 hold before strobe");
        strobe();
        check_all("R4 R1 load after strobe");
      end
    end
    send({16'h0, mk(1'b0, 1'b0, 2'd0, 12'hFFF)}, 16);
    strobe();
    check_all("R1 full-scale code");

    // R3: junk leading byte discarded
    send({8'h0, 8'hFF, mk(1'b0, 1'b0, 2'd2, 12'hABC)}, 24);
    strobe();
    check_all("R3 leading bits dropped");

    // R8: transparent while strobe held low, independent of chip select
    ldac_n = 1'b0;
    strobe_low = 1'b1;
    wait_clk(8);
    send({16'h0, mk(1'b0, 1'b0, 2'd3, 12'h5C3)}, 16);
    check_all("R8 transparent during frame");
    ldac_n = 1'b1;
    strobe_low = 1'b0;
    wait_clk(8);

    // R6: single channel off, no staging write
    send({16'h0, mk(1'b0, 1'b1, 2'd1, 12'h123)}, 16);
    check_all("R6 single off");
    strobe();
    check_all("R6 staging untouched");

    // R5: all off regardless of other bits
    send({16'h0, mk(1'b1, 1'b0, 2'd2, 12'h777)}, 16);
    check_all("R5 all off");

    // R7 R11: loads while off, wake one channel at a time
    send({16'h0, mk(1'b0, 1'b0, 2'd0, 12'h246)}, 16);
    check_all("R7 wake addressed only");
    strobe();
    check_all("R11 others stay zero");
    send({16'h0, mk(1'b0, 1'b0, 2'd1, 12'h9E1)}, 16);
    check_all("R11 live code revealed on wake");
    strobe();
    check_all("R11 after strobe");

    // R9: asynchronous clear, flags kept
    clr_n = 1'b0;
    wait_clk(3);
    for (int c = 0; c < 4; c++) begin
      in_m[c] = '0; out_m[c] = '0;
    end
    check_all("R9 clear active");
    clr_n = 1'b1;
    wait_clk(3);
    check_all("R9 after clear");

    // R2: serial clocks with chip select high do nothing; empty frame replays held word
    for (int i = 0; i < 20; i++) begin
      sdi = i[0];
      sclk = 1'b1;
      wait_clk(3);
      sclk = 1'b0;
      wait_clk(3);
    end
    cs_n = 1'b0;
    wait_clk(6);
    cs_n = 1'b1;
    wait_clk(10);
    apply(last_w);
    strobe();
    check_all("R2 R9 shift register kept");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule